// File: doc/BRIEF.md
# Video Capture Interrupt Status

This block keeps the sticky interrupt flags for one capture channel and one display path of a video port. Four event sources feed it: completion of a capture, a capture FIFO overrun, a general-purpose pin event, and a display-complete that software has not yet acknowledged. The capture-complete event depends on the capture mode. In field/frame video mode it follows the field or frame completion strobes, filtered by the capture control bits. In raw and transport-stream modes it comes from an internal compare of the line/sample counter against a stop position.

Software reads the flags and the enable mask as two 32-bit words. It clears a flag by writing 1 to that flag's position and writes the enable mask directly. The interrupt line is high while any enabled flag is set. The capture datapath, FIFO, DMA engine and display engine are outside this block and appear only as strobes and level flags.

Top module: `vcap_irq_status`

## Requirements
- R1: After reset, every bit of the status word and every bit of the enable word reads 0, and `irq` is low.
- R2: Flags sit at fixed status positions: capture complete at bit 18, overrun at bit 17, general-purpose event at bit 16, display-not-acknowledged at bit 14. Bit 15 and all other bits read 0 in both words, and writing them has no effect.
- R3: A flag stays set once set. Writing the status word (`reg_sel`=0) with 1 in a flag's position clears it on the next edge. A 0 leaves it unchanged.
- R4: When a set event and a write-1 clear of the same flag fall in one cycle, the flag ends set.
- R5: In video mode (`cap_mode`=0) the capture flag is set from `frm_done` when `ctl_frame`=1. Otherwise, with `ctl_cont`=1 it is set from `fld1_done` or `fld2_done`. With `ctl_cont`=0 it is set from `fld1_done` gated by `ctl_fld1` and from `fld2_done` gated by `ctl_fld2`.
- R6: In raw mode (`cap_mode`=1) and stream mode (`cap_mode`=2), the capture flag is set when `cnt_valid` is high and {`line_cnt`,`samp_cnt`} equals {`line_stop`,`samp_stop`}. It is set two edges after the first matching cycle, once per run of matching cycles. Field and frame strobes are ignored in these modes.
- R7: `ovr_evt` sets status bit 17 on the next edge.
- R8: `gpio_evt` sets status bit 16 on the next edge.
- R9: `disp_gate` sets status bit 14 on the next edge if any of `disp_f1`, `disp_f2`, `disp_frm` is high. With none of them high it has no effect.
- R10: Writing the enable word (`reg_sel`=1) loads the flag positions of `reg_wdata`. `irq` is high exactly when some flag is set and also enabled, and flags latch even while their enable is 0.
- R11: With `cap_mode`=3 the capture flag is never set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| cap_mode | input | 2 | 0 video, 1 raw, 2 stream, 3 off |
| ctl_cont | input | 1 | Continuous capture control |
| ctl_frame | input | 1 | Frame-based capture control |
| ctl_fld1 | input | 1 | Field 1 capture select |
| ctl_fld2 | input | 1 | Field 2 capture select |
| fld1_done | input | 1 | Field 1 capture complete strobe |
| fld2_done | input | 1 | Field 2 capture complete strobe |
| frm_done | input | 1 | Frame capture complete strobe |
| cnt_valid | input | 1 | Data counter valid this cycle |
| line_cnt | input | LINE_W | Data counter line part |
| samp_cnt | input | SAMP_W | Data counter sample part |
| line_stop | input | LINE_W | Stop line |
| samp_stop | input | SAMP_W | Stop sample |
| ovr_evt | input | 1 | Capture FIFO overrun strobe |
| gpio_evt | input | 1 | General-purpose pin event strobe |
| disp_f1 | input | 1 | Display field 1 complete flag still set |
| disp_f2 | input | 1 | Display field 2 complete flag still set |
| disp_frm | input | 1 | Display frame complete flag still set |
| disp_gate | input | 1 | Start of next display gating field/frame strobe |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 1 | 0 status word, 1 enable word |
| reg_wdata | input | DATA_W | Write data |
| sts_rd | output | DATA_W | Status word |
| ena_rd | output | DATA_W | Enable word |
| irq | output | 1 | Combined interrupt |

## Verification
Some properties are checked on every cycle:
- A set event is visible on the next cycle, including when it coincides with a clear.
- An uncleared flag holds its value.
- The compare pulse never lasts two cycles.
- An enable write lands as written.
- `irq` never rises with an empty enable mask.
- The capture flag cannot appear while capture is off.

Only the bench scenarios can show the rest:
- the mode-dependent choice of capture source, such as which field strobe counts under which control bits;
- the two-edge latency of the stop compare;
- that a held match yields a single set;
- that gate starts without a pending display flag and writes to unused bit positions leave the state untouched.

// File: rtl/vcap_irq_pkg.sv
package vcap_irq_pkg;

  localparam int unsigned NUM_SRC  = 4;
  localparam int unsigned POS_CAP  = 18;
  localparam int unsigned POS_OVR  = 17;
  localparam int unsigned POS_GPIO = 16;
  localparam int unsigned POS_DCNA = 14;

  typedef enum logic [1:0] {
    MODE_VIDEO  = 2'd0,
    MODE_RAW    = 2'd1,
    MODE_STREAM = 2'd2,
    MODE_OFF    = 2'd3
  } cap_mode_e;

  // Source index -> register bit position; software decodes these.
  function automatic int unsigned src_pos(input int unsigned idx);
    case (idx)
      0:       return POS_CAP;
      1:       return POS_OVR;
      2:       return POS_GPIO;
      default: return POS_DCNA;
    endcase
  endfunction

endpackage

// File: rtl/vcap_stop_cmp.sv
module vcap_stop_cmp #(
  parameter int unsigned LINE_W = 11,
  parameter int unsigned SAMP_W = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cnt_valid,
  input  logic [LINE_W-1:0] line_cnt,
  input  logic [SAMP_W-1:0] samp_cnt,
  input  logic [LINE_W-1:0] line_stop,
  input  logic [SAMP_W-1:0] samp_stop,
  output logic              hit
);

  localparam int unsigned POS_W = LINE_W + SAMP_W;

  logic [POS_W-1:0] pos_now, pos_end;
  logic             match_c, match_q, hit_d;

  always_comb begin
    pos_now = {line_cnt, samp_cnt};
    pos_end = {line_stop, samp_stop};
    match_c = cnt_valid && (pos_now == pos_end);
    hit_d   = match_c && !match_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      match_q <= 1'b0;
      hit     <= 1'b0;
    end else begin
      match_q <= match_c;
      hit     <= hit_d;
    end
  end

  // R6: one pulse per run of matching cycles
  assert_hit_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
    hit |=> !hit);

endmodule

// File: rtl/vcap_cap_sel.sv
module vcap_cap_sel
  import vcap_irq_pkg::*;
(
  input  logic [1:0] cap_mode,
  input  logic       ctl_cont,
  input  logic       ctl_frame,
  input  logic       ctl_fld1,
  input  logic       ctl_fld2,
  input  logic       fld1_done,
  input  logic       fld2_done,
  input  logic       frm_done,
  input  logic       stop_hit,
  output logic       cap_evt
);

  logic video_evt;

  always_comb begin
    if (ctl_frame)      video_evt = frm_done;
    else if (ctl_cont)  video_evt = fld1_done | fld2_done;
    else                video_evt = (ctl_fld1 & fld1_done) | (ctl_fld2 & fld2_done);

    case (cap_mode_e'(cap_mode))
      MODE_VIDEO:             cap_evt = video_evt;
      MODE_RAW, MODE_STREAM:  cap_evt = stop_hit;
      default:                cap_evt = 1'b0;
    endcase
  end

endmodule

// File: rtl/vcap_sticky_bit.sv
module vcap_sticky_bit (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic clr_i,
  output logic q
);

  logic q_d;

  always_comb q_d = set_i | (q & ~clr_i);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= 1'b0;
    else        q <= q_d;
  end

  // R4: a set is never lost, even against a clear
  assert_set_wins_R4: assert property (@(posedge clk) disable iff (!rst_n)
    set_i |=> q);
  // R3: flag holds unless cleared
  assert_flag_holds_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (q && !clr_i) |=> q);
  // R3: flag never rises without a set
  assert_no_spurious_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!q && !set_i) |=> !q);

endmodule

// File: rtl/vcap_irq_status.sv
module vcap_irq_status
  import vcap_irq_pkg::*;
#(
  parameter int unsigned LINE_W = 11,
  parameter int unsigned SAMP_W = 12,
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        cap_mode,
  input  logic              ctl_cont,
  input  logic              ctl_frame,
  input  logic              ctl_fld1,
  input  logic              ctl_fld2,
  input  logic              fld1_done,
  input  logic              fld2_done,
  input  logic              frm_done,
  input  logic              cnt_valid,
  input  logic [LINE_W-1:0] line_cnt,
  input  logic [SAMP_W-1:0] samp_cnt,
  input  logic [LINE_W-1:0] line_stop,
  input  logic [SAMP_W-1:0] samp_stop,
  input  logic              ovr_evt,
  input  logic              gpio_evt,
  input  logic              disp_f1,
  input  logic              disp_f2,
  input  logic              disp_frm,
  input  logic              disp_gate,
  input  logic              reg_wr,
  input  logic              reg_sel,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] sts_rd,
  output logic [DATA_W-1:0] ena_rd,
  output logic              irq
);

  logic               stop_hit, cap_evt, dcna_evt;
  logic [NUM_SRC-1:0] src_set, src_clr, sts_q;
  logic [NUM_SRC-1:0] wr_bits, ena_d, ena_q;
  logic               ena_ce;

  vcap_stop_cmp #(.LINE_W(LINE_W), .SAMP_W(SAMP_W)) u_cmp (
    .clk       (clk),
    .rst_n     (rst_n),
    .cnt_valid (cnt_valid),
    .line_cnt  (line_cnt),
    .samp_cnt  (samp_cnt),
    .line_stop (line_stop),
    .samp_stop (samp_stop),
    .hit       (stop_hit)
  );

  vcap_cap_sel u_sel (
    .cap_mode  (cap_mode),
    .ctl_cont  (ctl_cont),
    .ctl_frame (ctl_frame),
    .ctl_fld1  (ctl_fld1),
    .ctl_fld2  (ctl_fld2),
    .fld1_done (fld1_done),
    .fld2_done (fld2_done),
    .frm_done  (frm_done),
    .stop_hit  (stop_hit),
    .cap_evt   (cap_evt)
  );

  always_comb begin
    dcna_evt   = disp_gate & (disp_f1 | disp_f2 | disp_frm);
    src_set[0] = cap_evt;
    src_set[1] = ovr_evt;
    src_set[2] = gpio_evt;
    src_set[3] = dcna_evt;
    for (int i = 0; i < NUM_SRC; i++) begin
      wr_bits[i] = reg_wdata[src_pos(i)];
      src_clr[i] = reg_wr & ~reg_sel & wr_bits[i];
    end
  end

  for (genvar gi = 0; gi < NUM_SRC; gi++) begin : g_flag
    vcap_sticky_bit u_bit (
      .clk   (clk),
      .rst_n (rst_n),
      .set_i (src_set[gi]),
      .clr_i (src_clr[gi]),
      .q     (sts_q[gi])
    );
  end

  // Enable register: explicit clock enable, separate next-state process
  always_comb begin
    ena_ce = reg_wr & reg_sel;
    ena_d  = ena_ce ? wr_bits : ena_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ena_q <= '0;
    else        ena_q <= ena_d;
  end

  always_comb begin
    sts_rd = '0;
    ena_rd = '0;
    for (int i = 0; i < NUM_SRC; i++) begin
      sts_rd[src_pos(i)] = sts_q[i];
      ena_rd[src_pos(i)] = ena_q[i];
    end
    irq = |(sts_q & ena_q);
  end

  // R10: enable write lands at flag positions only
  assert_ena_load_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_sel) |=> (ena_rd[POS_CAP]  == $past(reg_wdata[POS_CAP])) &&
                            (ena_rd[POS_DCNA] == $past(reg_wdata[POS_DCNA])));
  // R10: no interrupt with an empty mask
  assert_irq_needs_ena_R10: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (ena_rd != '0));
  // R9: pending display flag at gate start raises the flag
  assert_dcna_set_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (disp_gate && (disp_f1 || disp_f2 || disp_frm)) |=> sts_rd[POS_DCNA]);
  // R8: general-purpose event latches
  assert_gpio_set_R8: assert property (@(posedge clk) disable iff (!rst_n)
    gpio_evt |=> sts_rd[POS_GPIO]);
  // R11: capture flag cannot appear while capture is off
  assert_off_no_cap_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (cap_mode == 2'd3 && !sts_rd[POS_CAP]) |=> !sts_rd[POS_CAP]);

endmodule

// File: tb/vcap_irq_status_test.sv
`timescale 1ns/1ps
module vcap_irq_status_test;

  localparam int unsigned LW = 11;
  localparam int unsigned SW = 12;
  localparam logic [31:0] FLAGS = 32'h0007_4000;

  logic          clk = 1'b0;
  logic          rst_n;
  logic [1:0]    cap_mode;
  logic          ctl_cont, ctl_frame, ctl_fld1, ctl_fld2;
  logic          fld1_done, fld2_done, frm_done, cnt_valid;
  logic [LW-1:0] line_cnt, line_stop;
  logic [SW-1:0] samp_cnt, samp_stop;
  logic          ovr_evt, gpio_evt, disp_f1, disp_f2, disp_frm, disp_gate;
  logic          reg_wr, reg_sel;
  logic [31:0]   reg_wdata, sts_rd, ena_rd;
  logic          irq;

  int vectors = 0;
  int errs    = 0;
  bit done    = 0;

  logic [31:0] m_sts, m_ena;
  logic        m_mq, m_hit;

  always #2.5 clk = ~clk;

  vcap_irq_status #(.LINE_W(LW), .SAMP_W(SW), .DATA_W(32)) uut (
    .clk(clk), .rst_n(rst_n), .cap_mode(cap_mode),
    .ctl_cont(ctl_cont), .ctl_frame(ctl_frame), .ctl_fld1(ctl_fld1), .ctl_fld2(ctl_fld2),
    .fld1_done(fld1_done), .fld2_done(fld2_done), .frm_done(frm_done),
    .cnt_valid(cnt_valid), .line_cnt(line_cnt), .samp_cnt(samp_cnt),
    .line_stop(line_stop), .samp_stop(samp_stop),
    .ovr_evt(ovr_evt), .gpio_evt(gpio_evt),
    .disp_f1(disp_f1), .disp_f2(disp_f2), .disp_frm(disp_frm), .disp_gate(disp_gate),
    .reg_wr(reg_wr), .reg_sel(reg_sel), .reg_wdata(reg_wdata),
    .sts_rd(sts_rd), .ena_rd(ena_rd), .irq(irq)
  );

  task automatic check(input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  task automatic idle();
    fld1_done = 0; fld2_done = 0; frm_done = 0; cnt_valid = 0;
    ovr_evt = 0; gpio_evt = 0; disp_gate = 0; reg_wr = 0; reg_sel = 0;
    reg_wdata = '0;
  endtask

  // Reference step built from the requirements, then compare.
  task automatic step(input string tag);
    logic [31:0] set_v, clr_v;
    logic        cap, mt;
    case (cap_mode)
      2'd0: cap = ctl_frame ? frm_done :
                  ctl_cont  ? (fld1_done | fld2_done) :
                              ((ctl_fld1 & fld1_done) | (ctl_fld2 & fld2_done));
      2'd1, 2'd2: cap = m_hit;
      default:    cap = 1'b0;
    endcase
    set_v     = '0;
    set_v[18] = cap;
    set_v[17] = ovr_evt;
    set_v[16] = gpio_evt;
    set_v[14] = disp_gate & (disp_f1 | disp_f2 | disp_frm);
    clr_v = (reg_wr && !reg_sel) ? (reg_wdata & FLAGS) : '0;
    mt = cnt_valid && (line_cnt == line_stop) && (samp_cnt == samp_stop);
    @(posedge clk); #1;
    m_sts = set_v | (m_sts & ~clr_v);
    if (reg_wr && reg_sel) m_ena = reg_wdata & FLAGS;
    m_hit = mt & ~m_mq;
    m_mq  = mt;
    check(tag, "status", sts_rd, m_sts);
    check(tag, "enable", ena_rd, m_ena);
    check(tag, "irq", {31'b0, irq}, {31'b0, |(m_sts & m_ena)});
  endtask

  task automatic wr(input logic sel, input logic [31:0] d, input string tag);
    reg_wr = 1; reg_sel = sel; reg_wdata = d;
    step(tag);
    idle();
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errs++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errs);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd7741));
    rst_n = 0; cap_mode = 2'd0;
    ctl_cont = 0; ctl_frame = 0; ctl_fld1 = 0; ctl_fld2 = 0;
    line_cnt = '0; samp_cnt = '0; line_stop = LW'(2); samp_stop = SW'(1);
    disp_f1 = 0; disp_f2 = 0; disp_frm = 0;
    idle();
    m_sts = '0; m_ena = '0; m_mq = 0; m_hit = 0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1;

    // R1: reset state
    check("R1", "status", sts_rd, 32'h0);
    check("R1", "enable", ena_rd, 32'h0);
    check("R1", "irq", {31'b0, irq}, 32'h0);

    // R8 and R10: flag latches with enable cleared, irq stays low
    gpio_evt = 1; step("R8"); idle();
    check("R8", "bit16", sts_rd, 32'h0001_0000);
    check("R10", "irq masked", {31'b0, irq}, 32'h0);

    // R2 and R10: all-ones enable write keeps flag positions only
    wr(1'b1, 32'hFFFF_FFFF, "R2");
    check("R2", "enable positions", ena_rd, FLAGS);
    check("R10", "irq enabled", {31'b0, irq}, 32'h1);

    // R3: zero write keeps; reserved and other positions have no effect
    wr(1'b0, 32'h0, "R3");
    wr(1'b0, 32'hFFF8_BFFF, "R2");
    check("R2", "writes elsewhere ignored", sts_rd, 32'h0001_0000);
    wr(1'b0, 32'h0001_0000, "R3");
    check("R3", "write-1 clear", sts_rd, 32'h0);

    // R4: set and clear together
    gpio_evt = 1; reg_wr = 1; reg_sel = 0; reg_wdata = 32'h0001_0000;
    step("R4"); idle();
    check("R4", "set wins", sts_rd, 32'h0001_0000);

    // R7: overrun
    ovr_evt = 1; step("R7"); idle();
    check("R7", "bit17", sts_rd & 32'h0002_0000, 32'h0002_0000);
    wr(1'b0, FLAGS, "R3");

    // R9: gate with no pending flag, then with one
    disp_gate = 1; step("R9"); idle();
    check("R9", "no pending", sts_rd, 32'h0);
    disp_f2 = 1; disp_gate = 1; step("R9"); idle(); disp_f2 = 0;
    check("R9", "pending", sts_rd, 32'h0000_4000);
    wr(1'b0, FLAGS, "R3");

    // R5: per-field selection
    cap_mode = 2'd0; ctl_cont = 0; ctl_frame = 0; ctl_fld1 = 1; ctl_fld2 = 0;
    fld2_done = 1; step("R5"); idle();
    check("R5", "field2 unselected", sts_rd, 32'h0);
    fld1_done = 1; step("R5"); idle();
    check("R5", "field1 selected", sts_rd, 32'h0004_0000);
    wr(1'b0, FLAGS, "R3");
    ctl_frame = 1; fld1_done = 1; step("R5"); idle();
    check("R5", "frame mode ignores field", sts_rd, 32'h0);
    frm_done = 1; step("R5"); idle();
    check("R5", "frame done", sts_rd, 32'h0004_0000);
    wr(1'b0, FLAGS, "R3");
    ctl_frame = 0; ctl_cont = 1; ctl_fld1 = 0; fld2_done = 1; step("R5"); idle();
    check("R5", "continuous field", sts_rd, 32'h0004_0000);
    wr(1'b0, FLAGS, "R3");

    // R6: raw mode compare, two-edge latency, single set per run
    cap_mode = 2'd1; frm_done = 1; step("R6"); idle();
    check("R6", "frame strobe ignored", sts_rd, 32'h0);
    line_cnt = LW'(2); samp_cnt = SW'(1); cnt_valid = 1;
    step("R6");
    check("R6", "not yet", sts_rd, 32'h0);
    cnt_valid = 1; step("R6");
    check("R6", "set", sts_rd, 32'h0004_0000);
    cnt_valid = 1; reg_wr = 1; reg_sel = 0; reg_wdata = FLAGS; step("R6");
    reg_wr = 0;
    cnt_valid = 1; step("R6"); cnt_valid = 1; step("R6");
    check("R6", "held match sets once", sts_rd, 32'h0);
    idle(); step("R6");

    // R6: stream mode behaves the same
    cap_mode = 2'd2; cnt_valid = 1; step("R6"); idle(); step("R6");
    check("R6", "stream set", sts_rd, 32'h0004_0000);
    wr(1'b0, FLAGS, "R3");

    // R11: capture off
    cap_mode = 2'd3; frm_done = 1; fld1_done = 1; cnt_valid = 1; step("R11");
    idle(); step("R11");
    check("R11", "off", sts_rd, 32'h0);

    // Random mix against the reference step (R3, R4, R5, R6, R10)
    for (int n = 0; n < 4000; n++) begin
      if (n % 48 == 0) begin
        cap_mode  = 2'($urandom_range(0, 3));
        ctl_cont  = 1'($urandom); ctl_frame = 1'($urandom);
        ctl_fld1  = 1'($urandom); ctl_fld2  = 1'($urandom);
      end
      fld1_done = ($urandom_range(0, 3) == 0);
      fld2_done = ($urandom_range(0, 3) == 0);
      frm_done  = ($urandom_range(0, 5) == 0);
      cnt_valid = 1'($urandom);
      line_cnt  = LW'($urandom_range(1, 3));
      samp_cnt  = SW'($urandom_range(0, 2));
      ovr_evt   = ($urandom_range(0, 7) == 0);
      gpio_evt  = ($urandom_range(0, 7) == 0);
      disp_f1   = ($urandom_range(0, 3) == 0);
      disp_f2   = ($urandom_range(0, 3) == 0);
      disp_frm  = ($urandom_range(0, 3) == 0);
      disp_gate = ($urandom_range(0, 5) == 0);
      reg_wr    = ($urandom_range(0, 3) == 0);
      reg_sel   = ($urandom_range(0, 3) == 0);
      reg_wdata = $urandom;
      step("random R3 R4 R6 R10");
    end
    idle();

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errs);
    $finish;
  end

endmodule